// File: doc/BRIEF.md
# Programming access unlock controller

This block keeps external program and erase commands disabled until a deliberate key ritual has been performed. It watches an already decoded mode code, a strobe line that idles high, and an eight-bit data bus. Its single enable flag, `unlocked`, is meant to gate every program and erase command elsewhere on the chip. After reset the flag is clear. It is cleared again whenever the lock mode code is presented.

To open access, the unlock mode code is applied while the strobe is high. Two low-going strobe pulses must then follow. The first carries 55h and the second carries AAh. The data bus is taken at the moment the strobe returns high. Each pulse must stay low for at least `MIN_PULSE` clocks, counted on the synchronised strobe.

A pulse that is too short, or that carries the wrong byte, sends the sequence back to its start and raises `seq_error` for one clock. Moving the mode code away from the unlock code in the middle of the sequence abandons it quietly. Strobe and data both pass through the same two-stage synchroniser, so the byte that is taken stays aligned with the strobe edge.

Top module: `prog_unlock_ctrl`

## Requirements
- R1: After reset, `unlocked` and `seq_error` are both 0.
- R2: A cycle with `mode_code` equal to the lock code (default 4'hA) clears `unlocked` on the next clock. It also abandons any partly entered sequence, so a later key pulse does not complete it.
- R3: Key pulses count only after the controller has been armed. Arming needs the unlock code (default 4'h5) on `mode_code` while the synchronised strobe is high. Pulses seen under any other code produce neither an unlock nor an error. A strobe that was already low when the unlock code arrived only arms the controller when it rises, and is not taken as a key.
- R4: When armed, a first pulse carrying 55h followed by a second pulse carrying AAh, each wide enough, sets `unlocked` to 1.
- R5: The key byte is the value on `data_in` at the end of the pulse, when the strobe returns high. Values present earlier in the same low period have no effect.
- R6: A pulse is wide enough when the synchronised strobe stays low for at least `MIN_PULSE` clocks. Longer pulses of any length are accepted. A shorter pulse raises an error and returns the sequence to its start.
- R7: A wrong byte in either key position raises an error and returns the sequence to its start. A fresh 55h, AAh pair then unlocks.
- R8: `seq_error` is high for exactly one clock per rejected pulse.
- R9: Changing `mode_code` away from the unlock code in mid-sequence abandons the sequence without an error. After return, the full two-byte key is needed again.
- R10: Once set, `unlocked` holds under every mode code other than the lock code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_code | input | MODE_W | Decoded test-mode code |
| strobe | input | 1 | Asynchronous strobe, idle high, pulses low |
| data_in | input | DATA_W | Asynchronous data bus, taken at the end of a pulse |
| unlocked | output | 1 | Program/erase access enable |
| seq_error | output | 1 | One-clock pulse when a key pulse is rejected |

## Verification
The bench builds the controller with `MIN_PULSE` = 6 and keeps the default mode codes and keys. The short width lets every pulse width from 1 to beyond the limit be swept in both key positions. Every one of the 256 byte values is tried in each key position, and the expected unlock state and error count are derived from simple arithmetic. Directed cases cover aborts, locking mid-sequence, data changing inside a pulse, and arming during a low strobe.

// File: rtl/unlock_pkg.sv
package unlock_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ARMED = 2'd1,
        SEQ_HALF  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic       done;
        logic       wide_enough;
        logic [7:0] sample;
    } pulse_evt_t;

    function automatic logic key_ok(input pulse_evt_t ev, input logic [7:0] key);
        return ev.wide_enough && (ev.sample == key);
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int STAGES = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              strobe_s,
    output logic [DATA_W-1:0] data_s
);
    localparam int VEC_W = DATA_W + 1;

    logic [VEC_W-1:0] stage [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage[gi] <= {1'b1, {DATA_W{1'b0}}};
                end else if (gi == 0) begin
                    stage[gi] <= {strobe_in, data_in};
                end else begin
                    stage[gi] <= stage[(gi == 0) ? 0 : gi-1];
                end
            end
        end
    endgenerate

    assign strobe_s = stage[STAGES-1][VEC_W-1];
    assign data_s   = stage[STAGES-1][DATA_W-1:0];
endmodule

// File: rtl/pulse_meter.sv
module pulse_meter
    import unlock_pkg::*;
#(
    parameter int MIN_PULSE = 25,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_s,
    input  logic [DATA_W-1:0] data_s,
    output pulse_evt_t        evt
);
    localparam int CNT_W = $clog2(MIN_PULSE + 1);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MIN_PULSE);

    logic             strobe_prev;
    logic [CNT_W-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_prev <= 1'b1;
            low_cnt     <= '0;
        end else begin
            strobe_prev <= strobe_s;
            if (strobe_s) begin
                low_cnt <= '0;
            end else if (low_cnt != CNT_SAT) begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        evt             = '0;
        evt.done        = strobe_s & ~strobe_prev;
        evt.wide_enough = (low_cnt >= CNT_SAT);
        evt.sample      = 8'(data_s);
    end
endmodule

// File: rtl/key_sequencer.sv
module key_sequencer
    import unlock_pkg::*;
#(
    parameter int                MODE_W      = 4,
    parameter logic [MODE_W-1:0] MODE_LOCK   = 4'hA,
    parameter logic [MODE_W-1:0] MODE_UNLOCK = 4'h5,
    parameter logic [7:0]        KEY_FIRST   = 8'h55,
    parameter logic [7:0]        KEY_SECOND  = 8'hAA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_code,
    input  logic              strobe_s,
    input  pulse_evt_t        evt,
    output logic              unlocked,
    output logic              seq_error
);
    seq_state_e state_q, state_d;
    logic       unl_d, err_d;

    always_comb begin
        state_d = state_q;
        unl_d   = unlocked;
        err_d   = 1'b0;
        if (mode_code == MODE_LOCK) begin
            state_d = SEQ_IDLE;
            unl_d   = 1'b0;
        end else if (mode_code != MODE_UNLOCK) begin
            state_d = SEQ_IDLE;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (strobe_s) state_d = SEQ_ARMED;
                end
                SEQ_ARMED: begin
                    if (evt.done) begin
                        if (key_ok(evt, KEY_FIRST)) state_d = SEQ_HALF;
                        else err_d = 1'b1;
                    end
                end
                SEQ_HALF: begin
                    if (evt.done) begin
                        state_d = SEQ_ARMED;
                        if (key_ok(evt, KEY_SECOND)) unl_d = 1'b1;
                        else err_d = 1'b1;
                    end
                end
                default: state_d = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SEQ_IDLE;
            unlocked  <= 1'b0;
            seq_error <= 1'b0;
        end else begin
            state_q   <= state_d;
            unlocked  <= unl_d;
            seq_error <= err_d;
        end
    end
endmodule

// File: rtl/prog_unlock_ctrl.sv
module prog_unlock_ctrl
    import unlock_pkg::*;
#(
    parameter int                MODE_W      = 4,
    parameter int                DATA_W      = 8,
    parameter int                SYNC_STAGES = 2,
    parameter int                MIN_PULSE   = 25,
    parameter logic [MODE_W-1:0] MODE_LOCK   = 4'hA,
    parameter logic [MODE_W-1:0] MODE_UNLOCK = 4'h5,
    parameter logic [7:0]        KEY_FIRST   = 8'h55,
    parameter logic [7:0]        KEY_SECOND  = 8'hAA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_code,
    input  logic              strobe,
    input  logic [DATA_W-1:0] data_in,
    output logic              unlocked,
    output logic              seq_error
);
    logic              strobe_s;
    logic [DATA_W-1:0] data_s;
    pulse_evt_t        meter_evt;

    strobe_sync #(.STAGES(SYNC_STAGES), .DATA_W(DATA_W)) u_sync (
        .clk(clk), .rst(rst), .strobe_in(strobe), .data_in(data_in),
        .strobe_s(strobe_s), .data_s(data_s)
    );

    pulse_meter #(.MIN_PULSE(MIN_PULSE), .DATA_W(DATA_W)) u_meter (
        .clk(clk), .rst(rst), .strobe_s(strobe_s), .data_s(data_s),
        .evt(meter_evt)
    );

    key_sequencer #(
        .MODE_W(MODE_W), .MODE_LOCK(MODE_LOCK), .MODE_UNLOCK(MODE_UNLOCK),
        .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
    ) u_seq (
        .clk(clk), .rst(rst), .mode_code(mode_code), .strobe_s(strobe_s),
        .evt(meter_evt), .unlocked(unlocked), .seq_error(seq_error)
    );
endmodule

// File: rtl/prog_unlock_chk.sv
module prog_unlock_chk #(
    parameter int                MODE_W      = 4,
    parameter logic [MODE_W-1:0] MODE_LOCK   = 4'hA,
    parameter logic [MODE_W-1:0] MODE_UNLOCK = 4'h5
) (
    input logic              clk,
    input logic              rst,
    input logic [MODE_W-1:0] mode_code,
    input logic              unlocked,
    input logic              seq_error,
    input logic              rise_evt
);
    p_reset_clear_r1: assert property (@(posedge clk) $past(rst) |-> (!unlocked && !seq_error));

    p_lock_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_code == MODE_LOCK) |=> !unlocked);

    p_quiet_outside_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_code != MODE_UNLOCK) |=> !seq_error);

    p_open_in_mode_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(mode_code == MODE_UNLOCK));

    p_err_on_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        seq_error |-> $past(rise_evt));

    p_err_single_r8: assert property (@(posedge clk) disable iff (rst)
        seq_error |=> !seq_error);

    p_hold_open_r10: assert property (@(posedge clk) disable iff (rst)
        (unlocked && mode_code != MODE_LOCK) |=> unlocked);
endmodule

bind prog_unlock_ctrl prog_unlock_chk #(
    .MODE_W(MODE_W), .MODE_LOCK(MODE_LOCK), .MODE_UNLOCK(MODE_UNLOCK)
) u_chk (
    .clk(clk), .rst(rst), .mode_code(mode_code), .unlocked(unlocked),
    .seq_error(seq_error), .rise_evt(meter_evt.done)
);

// File: tb/sim_prog_unlock_ctrl.sv
`timescale 1ns/1ps
module sim_prog_unlock_ctrl;
    localparam int         MINW    = 6;
    localparam logic [3:0] M_LOCK  = 4'hA;
    localparam logic [3:0] M_UNL   = 4'h5;
    localparam logic [3:0] M_NEUT  = 4'h0;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] mode_code = M_NEUT;
    logic       strobe = 1'b1;
    logic [7:0] data_in = 8'h00;
    logic       unlocked, seq_error;

    int total = 0, bad = 0, errcnt = 0, double_err = 0;
    logic prev_err = 1'b0;
    bit finished = 0;

    always #4 clk = ~clk;

    prog_unlock_ctrl #(.MIN_PULSE(MINW)) u0 (
        .clk(clk), .rst(rst), .mode_code(mode_code), .strobe(strobe),
        .data_in(data_in), .unlocked(unlocked), .seq_error(seq_error)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (seq_error) errcnt++;
            if (seq_error && prev_err) double_err++;
            prev_err = seq_error;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse(input logic [7:0] early, input logic [7:0] late,
                         input int width, input int late_n);
        strobe = 1'b0;
        data_in = early;
        for (int i = 0; i < width; i++) begin
            if (width - i == late_n) data_in = late;
            @(posedge clk);
            #1;
        end
        strobe = 1'b1;
        cyc(6);
    endtask

    task automatic key(input logic [7:0] b, input int width);
        pulse(b, b, width, 0);
    endtask

    task automatic arm();
        mode_code = M_UNL;
        strobe = 1'b1;
        cyc(4);
    endtask

    task automatic lock();
        mode_code = M_LOCK;
        cyc(2);
        mode_code = M_NEUT;
        cyc(2);
    endtask

    initial begin
        int e0;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        @(negedge clk);
        check(unlocked == 0, "R1 unlocked after reset", unlocked, 0);
        check(seq_error == 0, "R1 error after reset", seq_error, 0);
        cyc(1);

        // R4 basic unlock, minimum widths
        e0 = errcnt;
        arm(); key(8'h55, MINW); key(8'hAA, MINW);
        check(unlocked == 1, "R4 unlock with 55h/AAh", unlocked, 1);
        check(errcnt == e0, "R4 no error on good key", errcnt - e0, 0);

        // R10 hold under all non-lock codes
        for (int m = 0; m < 16; m++) begin
            if (m[3:0] != M_LOCK) begin
                mode_code = m[3:0];
                cyc(3);
                check(unlocked == 1, "R10 stays unlocked", unlocked, 1);
            end
        end
        lock();
        check(unlocked == 0, "R2 lock clears", unlocked, 1'b0);

        // R6 width sweep, first and second position
        for (int pos = 0; pos < 2; pos++) begin
            for (int w = 1; w <= 3 * MINW; w++) begin
                int exp_err;
                e0 = errcnt;
                arm();
                key(8'h55, pos == 0 ? w : MINW);
                key(8'hAA, pos == 1 ? w : MINW);
                exp_err = (w >= MINW) ? 0 : (pos == 0 ? 2 : 1);
                check(unlocked == (w >= MINW), "R6 width unlock", unlocked, w >= MINW);
                check(errcnt - e0 == exp_err, "R6 width error count", errcnt - e0, exp_err);
                lock();
            end
        end

        // R7 byte sweeps, first and second position
        for (int b = 0; b < 256; b++) begin
            e0 = errcnt;
            arm(); key(b[7:0], MINW); key(8'hAA, MINW);
            check(unlocked == (b == 'h55), "R7 first byte", unlocked, b == 'h55);
            check(errcnt - e0 == ((b == 'h55) ? 0 : 2), "R7 first byte errors",
                  errcnt - e0, (b == 'h55) ? 0 : 2);
            lock();
            e0 = errcnt;
            arm(); key(8'h55, MINW); key(b[7:0], MINW);
            check(unlocked == (b == 'hAA), "R7 second byte", unlocked, b == 'hAA);
            check(errcnt - e0 == ((b == 'hAA) ? 0 : 1), "R7 second byte errors",
                  errcnt - e0, (b == 'hAA) ? 0 : 1);
            lock();
        end

        // R7 restart after a wrong second byte
        e0 = errcnt;
        arm(); key(8'h55, MINW); key(8'h12, MINW); key(8'h55, MINW); key(8'hAA, MINW);
        check(unlocked == 1, "R7 restart then unlock", unlocked, 1);
        check(errcnt - e0 == 1, "R7 restart errors", errcnt - e0, 1);
        lock();

        // R9 abort by leaving unlock mode
        e0 = errcnt;
        arm(); key(8'h55, MINW);
        mode_code = M_NEUT; cyc(3);
        arm(); key(8'hAA, MINW);
        check(unlocked == 0, "R9 abort no unlock", unlocked, 0);
        check(errcnt - e0 == 1, "R9 AA after abort is a first-key error", errcnt - e0, 1);
        key(8'h55, MINW); key(8'hAA, MINW);
        check(unlocked == 1, "R9 full key after abort", unlocked, 1);
        lock();
        e0 = errcnt;
        arm(); key(8'h55, MINW);
        mode_code = M_NEUT; key(8'hAA, MINW);
        check(errcnt == e0, "R9 no error on abort", errcnt - e0, 0);
        check(unlocked == 0, "R9 pulse outside mode", unlocked, 0);
        lock();

        // R2 lock mid-sequence
        arm(); key(8'h55, MINW);
        lock();
        arm(); key(8'hAA, MINW);
        check(unlocked == 0, "R2 lock abandons sequence", unlocked, 0);
        lock();

        // R3 no arming outside unlock mode
        e0 = errcnt;
        mode_code = M_NEUT; cyc(2);
        key(8'h55, MINW); key(8'hAA, MINW);
        check(unlocked == 0, "R3 keys outside mode", unlocked, 0);
        check(errcnt == e0, "R3 no error outside mode", errcnt - e0, 0);
        // R3 unlock code arrives during a low strobe
        e0 = errcnt;
        strobe = 1'b0; data_in = 8'h55; cyc(2);
        mode_code = M_UNL;
        cyc(2 * MINW);
        strobe = 1'b1; cyc(6);
        key(8'hAA, MINW);
        check(unlocked == 0, "R3 arming pulse not a key", unlocked, 0);
        check(errcnt - e0 == 1, "R3 AA as first key errs", errcnt - e0, 1);
        lock();

        // R5 byte taken at end of pulse
        arm();
        pulse(8'h00, 8'h55, MINW + 4, 2);
        key(8'hAA, MINW);
        check(unlocked == 1, "R5 late 55h accepted", unlocked, 1);
        lock();
        e0 = errcnt;
        arm();
        pulse(8'h55, 8'h00, MINW + 4, 3);
        key(8'hAA, MINW);
        check(unlocked == 0, "R5 early 55h ignored", unlocked, 0);
        check(errcnt - e0 == 2, "R5 early 55h errors", errcnt - e0, 2);
        lock();

        check(double_err == 0, "R8 error pulse one clock", double_err, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule